// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Flag Tracker

This block follows the life of each channel of a four-channel DMA controller. It does not move data. It watches single-cycle event pulses and two level inputs per channel, and from them it keeps a pending bit, a busy bit, a completion flag and an error flag. Software sees these bits through a small byte-wide register port with a 3-bit offset. It acknowledges completion and error flags by writing ones to them.

Each channel raises an interrupt request line while it holds a completion or error flag. Every state bit is registered and changes on the rising clock edge after the event that causes it. Register reads are combinational from the current state. A spare scratch byte is provided so that software can stage wide accesses.

Top module: `dma_status_flags`

## Requirements
- R1: After reset the flag, status and scratch registers read 0x00 and every irq_o bit is low.
- R2: The flag register is at offset 3. Bits 7:4 hold the error flags of channels 3..0, and bits 3:0 hold the completion flags of channels 3..0.
- R3: The status register is at offset 4. Bits 7:4 hold the busy bits of channels 3..0, and bits 3:0 hold the pending bits of channels 3..0. A write to offset 4 changes nothing.
- R4: A write to offset 3 clears every flag whose data bit is 1. It leaves every flag whose data bit is 0 unchanged.
- R5: If a hardware set event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R6: An err_i pulse on a channel sets that channel's error flag.
- R7: When rpt_inf_i is low, trn_done_i sets the completion flag and blk_done_i does not. When rpt_inf_i is high, blk_done_i sets the completion flag and trn_done_i does not.
- R8: xfer_start_i sets the busy bit. The busy bit clears when ch_dis_i is high, when an error pulse arrives, or when a completion set event arrives. If a clear condition and a start arrive in the same cycle, the clear wins.
- R9: blk_pend_i sets the pending bit. xfer_start_i or abort_i clears it. A new blk_pend_i in the same cycle as a clear leaves the bit set.
- R10: The scratch byte at offset 6 reads back the last value written to it.
- R11: Reads of offsets 0, 1, 2, 5 and 7 return 0x00. Writes to those offsets change no register.
- R12: irq_o[n] is the OR of channel n's error flag and completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_pend_i | input | 4 | Block waiting, one pulse bit per channel |
| xfer_start_i | input | 4 | Block transfer starts, per channel |
| abort_i | input | 4 | Transfer aborted, per channel |
| blk_done_i | input | 4 | Block transfer finished, per channel |
| trn_done_i | input | 4 | Whole transaction finished, per channel |
| err_i | input | 4 | Error detected, per channel |
| ch_dis_i | input | 4 | Channel disabled (level) |
| rpt_inf_i | input | 4 | Unlimited repeat enabled (level) |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| irq_o | output | 4 | Interrupt request per channel |

## Verification
The hardest situations to reach are the same-cycle collisions: a flag set against its own write-one-to-clear, a start against a disable or an error, and a new pending pulse against an abort. Each of these needs a write on the register port lined up with a hardware pulse in the same cycle. The vector table places the event pulses and the register write in one row, so each collision occupies exactly one clock. After that clock the bench reads both registers back. The unlimited-repeat vectors drive a transaction-done pulse that must be ignored, and then a block-done pulse that must set the flag.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] FLAG_OFF = 3'd3;
  localparam logic [ADDR_W-1:0] STAT_OFF = 3'd4;
  localparam logic [ADDR_W-1:0] SCR_OFF  = 3'd6;
endpackage

// File: rtl/dma_ch_flags.sv
module dma_ch_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blk_pend_i,
  input  logic start_i,
  input  logic abort_i,
  input  logic blk_done_i,
  input  logic trn_done_i,
  input  logic err_i,
  input  logic dis_i,
  input  logic rpt_inf_i,
  input  logic clr_done_i,
  input  logic clr_err_i,
  output logic pend_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  logic pend_q, busy_q, done_q, err_q;
  logic cmp_set;

  // unlimited repeat flags each block instead of the transaction
  assign cmp_set = rpt_inf_i ? blk_done_i : trn_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= blk_pend_i | (pend_q & ~(start_i | abort_i));
      busy_q <= ~(dis_i | cmp_set | err_i) & (start_i | busy_q);
      done_q <= cmp_set | (done_q & ~clr_done_i);
      err_q  <= err_i | (err_q & ~clr_err_i);
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  // R9
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || abort_i) && !blk_pend_i |=> !pend_o);
  // R8
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i || err_i) |=> !busy_o);
  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_o);
  // R7
  rpt_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_inf_i && blk_done_i |=> done_o);
  // R4
  w1c_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_err_i && !err_i |=> !err_o);
endmodule

// File: rtl/dma_stat_regs.sv
module dma_stat_regs
  import dma_stat_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned DATA_W = 2 * NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] err_i,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] busy_i,
  input  logic [NUM_CH-1:0] pend_i,
  output logic [NUM_CH-1:0] clr_err_o,
  output logic [NUM_CH-1:0] clr_done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] scr_q;
  logic              flag_wr, scr_wr;

  assign flag_wr = we_i && (addr_i == FLAG_OFF);
  assign scr_wr  = we_i && (addr_i == SCR_OFF);

  assign clr_done_o = flag_wr ? wdata_i[NUM_CH-1:0]      : '0;
  assign clr_err_o  = flag_wr ? wdata_i[DATA_W-1:NUM_CH] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     scr_q <= '0;
    else if (scr_wr) scr_q <= wdata_i;
  end

  always_comb begin
    unique case (addr_i)
      FLAG_OFF: rdata_o = {err_i, done_i};
      STAT_OFF: rdata_o = {busy_i, pend_i};
      SCR_OFF:  rdata_o = scr_q;
      default:  rdata_o = '0;
    endcase
  end

  // R10
  scr_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scr_wr |=> scr_q == $past(wdata_i));
endmodule

// File: rtl/dma_status_flags.sv
module dma_status_flags
  import dma_stat_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned DATA_W = 2 * NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] blk_pend_i,
  input  logic [NUM_CH-1:0] xfer_start_i,
  input  logic [NUM_CH-1:0] abort_i,
  input  logic [NUM_CH-1:0] blk_done_i,
  input  logic [NUM_CH-1:0] trn_done_i,
  input  logic [NUM_CH-1:0] err_i,
  input  logic [NUM_CH-1:0] ch_dis_i,
  input  logic [NUM_CH-1:0] rpt_inf_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] pend_v, busy_v, done_v, err_v;
  logic [NUM_CH-1:0] clr_err, clr_done;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_ch_flags u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .blk_pend_i (blk_pend_i[c]),
      .start_i    (xfer_start_i[c]),
      .abort_i    (abort_i[c]),
      .blk_done_i (blk_done_i[c]),
      .trn_done_i (trn_done_i[c]),
      .err_i      (err_i[c]),
      .dis_i      (ch_dis_i[c]),
      .rpt_inf_i  (rpt_inf_i[c]),
      .clr_done_i (clr_done[c]),
      .clr_err_i  (clr_err[c]),
      .pend_o     (pend_v[c]),
      .busy_o     (busy_v[c]),
      .done_o     (done_v[c]),
      .err_o      (err_v[c])
    );
  end

  dma_stat_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .err_i      (err_v),
    .done_i     (done_v),
    .busy_i     (busy_v),
    .pend_i     (pend_v),
    .clr_err_o  (clr_err),
    .clr_done_o (clr_done),
    .rdata_o    (rdata_o)
  );

  assign irq_o = err_v | done_v;

  // R12
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |err_i |=> |irq_o);
endmodule

// File: tb/dma_status_flags_bench.sv
module dma_status_flags_bench;
  typedef struct packed {
    logic [3:0] bp, st, ab, bd, td, er, ds, rp;
    logic       we;
    logic [2:0] ad;
    logic [7:0] wd;
    logic [7:0] ef;
    logic [7:0] es;
  } vec_t;

  localparam int NV = 18;
  // fields: pend start abort bdone tdone err dis rpt | we addr wdata | exp_flag exp_stat
  localparam vec_t VECS [NV] = '{
    '{4'h3,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0, 1'b0,3'd0,8'h00, 8'h00,8'h03}, // R9 set
    '{4'h4,4'h1,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0, 1'b0,3'd0,8'h00, 8'h00,8'h16}, // R9 start clr, R8
    '{4'h0,4'h4,4'h2,4'h0,4'h0,4'h0,4'h0,4'h0, 1'b0,3'd0,8'h00, 8'h00,8'h50}, // R9 abort
    '{4'h0,4'h0,4'h0,4'h0,4'h1,4'h0,4'h0,4'h0, 1'b0,3'd0,8'h00, 8'h01,8'h40}, // R7 R8
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h4,4'h0,4'h0, 1'b0,3'd0,8'h00, 8'h41,8'h00}, // R6 R8
    '{4'h0,4'hA,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0, 1'b0,3'd0,8'h00, 8'h41,8'hA0}, // R8
    '{4'h0,4'h0,4'h0,4'h0,4'h8,4'h0,4'h0,4'h8, 1'b0,3'd0,8'h00, 8'h41,8'hA0}, // R7 td ignored
    '{4'h0,4'h0,4'h0,4'h8,4'h0,4'h0,4'h0,4'h8, 1'b0,3'd0,8'h00, 8'h49,8'h20}, // R7 repeat bd
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h2,4'h0, 1'b0,3'd0,8'h00, 8'h49,8'h00}, // R8 disable
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0, 1'b1,3'd3,8'h01, 8'h48,8'h00}, // R4
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0, 1'b1,3'd3,8'h00, 8'h48,8'h00}, // R4 zero
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0, 1'b1,3'd4,8'hFF, 8'h48,8'h00}, // R3 ignored
    '{4'h0,4'h0,4'h0,4'h0,4'h2,4'h1,4'h0,4'h0, 1'b1,3'd3,8'hFF, 8'h12,8'h00}, // R5
    '{4'h0,4'h1,4'h0,4'h0,4'h0,4'h0,4'h1,4'h0, 1'b0,3'd0,8'h00, 8'h12,8'h00}, // R8 dis beats start
    '{4'h0,4'h2,4'h0,4'h0,4'h0,4'h2,4'h0,4'h0, 1'b0,3'd0,8'h00, 8'h32,8'h00}, // R8 err beats start
    '{4'h1,4'h0,4'h1,4'h0,4'h0,4'h0,4'h0,4'h0, 1'b0,3'd0,8'h00, 8'h32,8'h01}, // R9 new pend wins
    '{4'h0,4'h0,4'h0,4'h1,4'h0,4'h0,4'h0,4'h0, 1'b0,3'd0,8'h00, 8'h32,8'h01}, // R7 bd ignored
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0, 1'b1,3'd3,8'h33, 8'h00,8'h01}  // R4 clear all
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] blk_pend_i = '0, xfer_start_i = '0, abort_i = '0, blk_done_i = '0;
  logic [3:0] trn_done_i = '0, err_i = '0, ch_dis_i = '0, rpt_inf_i = '0;
  logic       we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  dma_status_flags u_dma_status_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .blk_pend_i(blk_pend_i), .xfer_start_i(xfer_start_i),
    .abort_i(abort_i), .blk_done_i(blk_done_i), .trn_done_i(trn_done_i), .err_i(err_i),
    .ch_dis_i(ch_dis_i), .rpt_inf_i(rpt_inf_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [7:0] exp);
    addr_i = a;
    #1;
    chk(tag, rdata_o, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    blk_pend_i = v.bp; xfer_start_i = v.st; abort_i = v.ab; blk_done_i = v.bd;
    trn_done_i = v.td; err_i = v.er; ch_dis_i = v.ds; rpt_inf_i = v.rp;
    we_i = v.we; addr_i = v.ad; wdata_i = v.wd;
    @(posedge clk_i);
    #1;
    blk_pend_i = '0; xfer_start_i = '0; abort_i = '0; blk_done_i = '0;
    trn_done_i = '0; err_i = '0; ch_dis_i = '0; we_i = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #10;
    // R1 reset state
    rd(3'd3, "R1 flag reset", 8'h00);
    rd(3'd4, "R1 stat reset", 8'h00);
    rd(3'd6, "R1 scratch reset", 8'h00);
    chk("R1 irq reset", {4'h0, irq_o}, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R12
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      rd(3'd3, $sformatf("R2 R4 R5 R6 R7 flag vec%0d", i), VECS[i].ef);
      rd(3'd4, $sformatf("R3 R8 R9 stat vec%0d", i), VECS[i].es);
      chk($sformatf("R12 irq vec%0d", i), {4'h0, irq_o}, {4'h0, VECS[i].ef[7:4] | VECS[i].ef[3:0]});
    end

    // R10 scratch read/write
    wr(3'd6, 8'hA5);
    rd(3'd6, "R10 scratch A5", 8'hA5);
    wr(3'd6, 8'h5A);
    rd(3'd6, "R10 scratch 5A", 8'h5A);

    // R11 unmapped reads and writes
    apply('{4'h0,4'h0,4'h0,4'h0,4'h0,4'h2,4'h0,4'h0, 1'b0,3'd0,8'h00, 8'h00,8'h00});
    for (int a = 0; a < 8; a++) begin
      if (a == 3 || a == 4 || a == 6) continue;
      wr(3'(a), 8'hFF);
      rd(3'(a), $sformatf("R11 unmapped %0d", a), 8'h00);
    end
    rd(3'd3, "R11 flag untouched", 8'h20);
    rd(3'd6, "R11 scratch untouched", 8'h5A);
    rd(3'd4, "R11 stat untouched", 8'h01);

    // R1 reset during operation
    @(negedge clk_i) rst_ni = 1'b0;
    #1;
    rd(3'd3, "R1 flag midreset", 8'h00);
    rd(3'd4, "R1 stat midreset", 8'h00);
    rd(3'd6, "R1 scratch midreset", 8'h00);
    chk("R1 irq midreset", {4'h0, irq_o}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule